// File: doc/BRIEF.md
# Power-Fail Guarded Static Memory Slave

This block is a byte-wide static memory behind an active-low control bus: a select strobe, a write strobe and an output strobe. The bidirectional data bus is split into an input byte, an output byte and an output-drive enable. Every control, address and data input is sampled on a fast internal clock. The block works out the bus mode from the strobes and writes one byte for each period in which select and write are both low.

Two digital supply flags come from an external monitor. One reports that the main supply has failed. The other reports that the part is running from its backup cell. While either flag is high, the block is deselected and stops driving its outputs. Every other input is ignored, and no write can land in the array. The array is never cleared, so its contents survive both supply states. The current mode is shown on a three-bit status output.

The array holds 2^AW bytes. The default AW of 10 keeps elaboration small. Setting AW to 17 gives the full 131072-byte organization.

Top module: `guarded_sram`

## Requirements
- R1: A byte is written only after a period in which the synchronized select and write strobes are both low; pulsing the write strobe while select is high writes nothing.
- R2: The byte committed is the input data present in the last clock cycle of the write period, stored at the address held during that period; the commit lands one clock after the period is seen to close.
- R3: With select high, the mode is 0 (deselect), the output enable is low, the output byte is 0, and the output and write strobes are ignored; this is also the state during reset.
- R4: With select and write low, the mode is 3 (write) and the outputs are not driven, whatever the output strobe is.
- R5: With select and output strobe low and write high, the mode is 1 (read) and the output enable is high with the stored byte at the current address on the output.
- R6: With select low and both the output and write strobes high, the mode is 2 (active, outputs off) and the output enable is low.
- R7: Lowering the write strobe during a read turns the output off and turns the cycle into a write.
- R8: While the supply-fail flag is high, the mode is 4, the outputs are off, and no strobe, address or data input changes the array.
- R9: While the backup-cell flag is high, the mode is 5 whatever the supply-fail flag is; the outputs are off and the stored bytes are kept through and after the backup state.
- R10: A supply flag raised at any point in a write period, including the cycle in which the commit would land, aborts that write; the address keeps its earlier byte even if the flag drops before the period closes.
- R11: The strobes pass through two flip-flops before use, so a strobe change made between clock edges is reflected in the mode after the second following rising edge and not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Select strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output strobe, active low |
| addr | input | AW | Byte address |
| din | input | 8 | Write data (input half of data bus) |
| dout | output | 8 | Read data (output half of data bus), 0 when not driven |
| dout_en | output | 1 | Drive enable for the data bus |
| pwr_fail | input | 1 | Main supply failed |
| on_backup | input | 1 | Running from the backup cell |
| mode | output | 3 | Current mode: 0 deselect, 1 read, 2 active outputs off, 3 write, 4 supply-fail deselect, 5 backup |

## Verification
Two functions can fall in the same cycle: the commit of a closing write period and a supply-fail flag. The bench ends a write period by raising select and holds off for two clock cycles so the synchronized close has reached the commit stage. It then raises the supply-fail flag for exactly the cycle in which the commit would land. It judges the result by reading that address back after power returns and expecting the byte from before the write. A second overlap lowers the write strobe during an ongoing read. The bench checks that the drive enable falls and that the new byte is later read back.

// File: rtl/guarded_sram.sv
module guarded_sram #(
  parameter int AW = 10,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel_n,
  input  logic          wr_n,
  input  logic          oe_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_en,
  input  logic          pwr_fail,
  input  logic          on_backup,
  output logic [2:0]    mode
);
  localparam int DEPTH = 1 << AW;
  localparam logic [2:0] M_DESEL = 3'd0;
  localparam logic [2:0] M_READ  = 3'd1;
  localparam logic [2:0] M_IDLE  = 3'd2;
  localparam logic [2:0] M_WRITE = 3'd3;
  localparam logic [2:0] M_FAIL  = 3'd4;
  localparam logic [2:0] M_BACK  = 3'd5;

  logic [DW-1:0] mem [DEPTH];

  logic [2:0]    ctl_s1, ctl_s2;
  logic [AW-1:0] a_s1, a_s2, hold_a;
  logic [DW-1:0] d_s1, d_s2, hold_d;
  logic          wr_act_q, wr_open;

  wire sel_s  = ctl_s2[2];
  wire wr_s   = ctl_s2[1];
  wire oe_s   = ctl_s2[0];
  wire pwr_bad  = pwr_fail | on_backup;
  wire wr_act_s = !sel_s && !wr_s;
  wire wr_commit = wr_open && !wr_act_s && !pwr_bad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_s1 <= 3'b111;
      ctl_s2 <= 3'b111;
      a_s1   <= '0;
      a_s2   <= '0;
      d_s1   <= '0;
      d_s2   <= '0;
    end else begin
      ctl_s1 <= {sel_n, wr_n, oe_n};
      ctl_s2 <= ctl_s1;
      a_s1   <= addr;
      a_s2   <= a_s1;
      d_s1   <= din;
      d_s2   <= d_s1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      wr_open  <= 1'b0;
      hold_a   <= '0;
      hold_d   <= '0;
    end else begin
      wr_act_q <= wr_act_s;
      if (pwr_bad)
        wr_open <= 1'b0;
      else if (wr_act_s && !wr_act_q)
        wr_open <= 1'b1;
      else if (!wr_act_s)
        wr_open <= 1'b0;
      if (wr_act_s) begin
        hold_a <= a_s2;
        hold_d <= d_s2;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_commit)
      mem[hold_a] <= hold_d;
  end

  always_comb begin
    if (on_backup)      mode = M_BACK;
    else if (pwr_fail)  mode = M_FAIL;
    else if (sel_s)     mode = M_DESEL;
    else if (!wr_s)     mode = M_WRITE;
    else if (!oe_s)     mode = M_READ;
    else                mode = M_IDLE;
  end

  assign dout_en = (mode == M_READ);
  assign dout    = dout_en ? mem[a_s2] : '0;
endmodule

module guarded_sram_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_n,
  input logic       wr_n,
  input logic       pwr_fail,
  input logic       on_backup,
  input logic       dout_en,
  input logic       wr_open,
  input logic       wr_commit
);
  logic [1:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cyc <= 2'd0;
    else if (cyc != 2'd3) cyc <= cyc + 2'd1;
  end

  p_commit_window_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && cyc == 2'd3) |-> $past(!sel_n && !wr_n, 3));

  p_desel_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && sel_n && $past(sel_n) && $past(sel_n, 2)) |-> !dout_en);

  p_write_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == 2'd3 && !sel_n && !wr_n && $past(!sel_n && !wr_n) && $past(!sel_n && !wr_n, 2)) |-> !dout_en);

  p_fail_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail || on_backup) |-> (!dout_en && !wr_commit));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_fail || on_backup) |=> !wr_open);
endmodule

bind guarded_sram guarded_sram_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n),
  .pwr_fail(pwr_fail), .on_backup(on_backup), .dout_en(dout_en),
  .wr_open(wr_open), .wr_commit(wr_commit)
);

// File: tb/sim_guarded_sram.sv
module sim_guarded_sram;
  localparam int AW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, wr_n = 1'b1, oe_n = 1'b1, pwr_fail = 1'b0, on_backup = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0] din = '0, dout;
  logic dout_en;
  logic [2:0] mode;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  guarded_sram #(.AW(AW), .DW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wr_n(wr_n), .oe_n(oe_n),
    .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .pwr_fail(pwr_fail), .on_backup(on_backup), .mode(mode));

  // {sel,wr,oe,pf,bk, addr[8], din[8], mode[3], en, dout[8]}
  localparam int NV = 15;
  localparam logic [32:0] TBL [NV] = '{
    {5'b11100, 8'h05, 8'h00, 3'd0, 1'b0, 8'h00},  // R3 deselect
    {5'b00100, 8'h05, 8'h11, 3'd3, 1'b0, 8'h00},  // R4 write, G high
    {5'b01000, 8'h05, 8'h00, 3'd1, 1'b1, 8'h11},  // R5 R1 read back
    {5'b10000, 8'h05, 8'hAA, 3'd0, 1'b0, 8'h00},  // R3 W/G ignored
    {5'b01000, 8'h05, 8'h00, 3'd1, 1'b1, 8'h11},  // R1 no write with E high
    {5'b00000, 8'h06, 8'h22, 3'd3, 1'b0, 8'h00},  // R4 write, G low
    {5'b01100, 8'h06, 8'h00, 3'd2, 1'b0, 8'h00},  // R6 active, off
    {5'b01000, 8'h06, 8'h00, 3'd1, 1'b1, 8'h22},  // R5
    {5'b00100, 8'h07, 8'h33, 3'd3, 1'b0, 8'h00},  // R4
    {5'b01000, 8'h07, 8'h00, 3'd1, 1'b1, 8'h33},  // R5
    {5'b00010, 8'h05, 8'h99, 3'd4, 1'b0, 8'h00},  // R8 supply fail
    {5'b01000, 8'h05, 8'h00, 3'd1, 1'b1, 8'h11},  // R8 nothing written
    {5'b01011, 8'h07, 8'h00, 3'd5, 1'b0, 8'h00},  // R9 backup wins
    {5'b01000, 8'h07, 8'h00, 3'd1, 1'b1, 8'h33},  // R9 retained
    {5'b01000, 8'h06, 8'h00, 3'd1, 1'b1, 8'h22}   // R9 retained
  };

  task automatic chk(input string tag, input logic [2:0] em, input logic ee, input logic [7:0] eq);
    tests++;
    if (mode !== em || dout_en !== ee || dout !== eq) begin
      fails++;
      $display("FAIL %s: mode=%0d en=%0b dout=%h expected mode=%0d en=%0b dout=%h",
               tag, mode, dout_en, dout, em, ee, eq);
    end
  endtask

  task automatic drive(input logic s, input logic w, input logic o, input logic [7:0] a, input logic [7:0] d);
    sel_n = s; wr_n = w; oe_n = o; addr = {2'b00, a}; din = d;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    drive(0, 0, 1, a, d); settle();
    drive(1, 1, 1, a, 8'h00); settle();
  endtask

  task automatic rd_chk(input string tag, input logic [7:0] a, input logic [7:0] eq);
    drive(0, 1, 0, a, 8'h00); settle();
    chk(tag, 3'd1, 1'b1, eq);
    drive(1, 1, 1, a, 8'h00); settle();
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run did not end, expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R3 reset state", 3'd0, 1'b0, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      v = TBL[i];
      sel_n = v[32]; wr_n = v[31]; oe_n = v[30]; pwr_fail = v[29]; on_backup = v[28];
      addr = {2'b00, v[27:20]}; din = v[19:12];
      settle();
      chk($sformatf("table row %0d", i), v[11:9], v[8], v[7:0]);
    end
    pwr_fail = 0; on_backup = 0;
    drive(1, 1, 1, 8'h00, 8'h00); settle();

    // R11: two-stage sync latency
    drive(0, 1, 0, 8'h05, 8'h00);
    @(negedge clk);
    chk("R11 after one edge", 3'd0, 1'b0, 8'h00);
    @(negedge clk);
    chk("R11 after two edges", 3'd1, 1'b1, 8'h11);
    drive(1, 1, 1, 8'h00, 8'h00); settle();

    // R2: data in last cycle of window wins
    drive(0, 0, 1, 8'h08, 8'h44); settle();
    din = 8'h55; @(negedge clk);
    drive(1, 1, 1, 8'h08, 8'h00); settle();
    rd_chk("R2 last data committed", 8'h08, 8'h55);

    // R7: W falls during a read
    drive(0, 1, 0, 8'h05, 8'h66); settle();
    chk("R7 read before W falls", 3'd1, 1'b1, 8'h11);
    wr_n = 0; repeat (2) @(negedge clk);
    chk("R7 outputs off, write mode", 3'd3, 1'b0, 8'h00);
    repeat (2) @(negedge clk);
    drive(1, 1, 1, 8'h05, 8'h00); settle();
    rd_chk("R7 write landed", 8'h05, 8'h66);

    // R10: mid-window supply pulse aborts
    wr_byte(8'h09, 8'h77);
    drive(0, 0, 1, 8'h09, 8'h88); settle();
    pwr_fail = 1; @(negedge clk);
    pwr_fail = 0; settle();
    drive(1, 1, 1, 8'h09, 8'h00); settle();
    rd_chk("R10 mid-window abort", 8'h09, 8'h77);

    // R10 + commit in same cycle as supply fail
    wr_byte(8'h0A, 8'h12);
    drive(0, 0, 1, 8'h0A, 8'h34); settle();
    sel_n = 1; wr_n = 1;
    repeat (2) @(negedge clk);
    pwr_fail = 1; @(negedge clk);
    pwr_fail = 0; settle();
    rd_chk("R10 fail at commit cycle", 8'h0A, 8'h12);

    // R8 control: same close without fail does commit
    drive(0, 0, 1, 8'h0A, 8'h34); settle();
    drive(1, 1, 1, 8'h0A, 8'h00); settle();
    rd_chk("R1 R8 normal close commits", 8'h0A, 8'h34);

    // R9: backup alone gives mode 5
    on_backup = 1; drive(0, 0, 0, 8'h0A, 8'hFF); settle();
    chk("R9 backup mode", 3'd5, 1'b0, 8'h00);
    on_backup = 0; drive(1, 1, 1, 8'h0A, 8'h00); settle();
    rd_chk("R9 contents kept", 8'h0A, 8'h34);

    finish_run();
  end
endmodule